// File: doc/BRIEF.md
# Indexed Display Register File with Unlock Key and Write Guard

This block holds the 64 indexed timing and extension registers of a display controller, together with three single-byte control registers that sit on the same byte-wide I/O port interface. Software selects a register by writing a 6-bit index to one port. It then reads or writes the selected byte through a companion data port.

Two independent guards filter the data-port writes. The first is a protect bit held in bit 7 of indexed register 0x11. When it is set, the low horizontal and vertical timing registers are frozen, and register 7 accepts only its bit 4. The second is a key flag. It opens the upper part of the index space, and it is armed or disarmed only by a two-register sequence: first a value goes into a compatibility register, then a value goes into a mode control register. The compatibility register has two port aliases, and one of them answers only while bit 0 of the misc output register is set.

Every register, the current index and the key flag are driven out as plain outputs for the downstream timing, mapping and mode logic.

Top module: `crtc_guard`

## Requirements
- R1: After reset, all 64 indexed registers, the index, the compatibility register, the mode control register and the key flag read 0, and the misc output register reads 0x01.
- R2: A write to port 0x3DF always loads the compatibility register. A write to port 0x3BF loads it only while bit 0 of the misc output register is 1. A write to port 0x3C2 loads the misc output register.
- R3: A write to port 0x3D8 loads the mode control register. If the compatibility register holds 0x03 at that moment and the written byte has bits 7 and 5 both set, the key flag becomes 1.
- R4: If a mode control write finds the compatibility register different from 0x03 and the written byte lacks bit 7 or bit 5, the key flag becomes 0. Every other mode control write leaves the key flag unchanged.
- R5: A write to port 0x3D4 loads bits 5:0 of the byte into the index. A read of port 0x3D4 returns the index with bits 7:6 zero.
- R6: A write to port 0x3D5 that no guard blocks stores the byte in the register selected by the index. A read of port 0x3D5 returns that register whatever the guard state.
- R7: While bit 7 of register 0x11 is 1, data writes to indices 0 to 6 and to index 0x35 leave the target unchanged.
- R8: While bit 7 of register 0x11 is 1, a data write to index 7 replaces only bit 4 and keeps bits 7:5 and 3:0.
- R9: While the key flag is 0, data writes to indices 0x19 to 0x3F leave the target unchanged, except writes to 0x33 and 0x35. While the key flag is 1, those writes succeed.
- R10: A read of any other port returns 0x00. All register outputs change on the clock edge that samples the write, and io_rdata follows io_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_we | input | 1 | Write strobe for the byte on io_wdata at io_addr |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data for io_addr |
| key_o | output | 1 | Extension unlock key flag |
| compat_o | output | 8 | Compatibility register |
| mode_o | output | 8 | Mode control register |
| misc_o | output | 8 | Misc output register |
| idx_o | output | 6 | Current register index |
| crtc_o | output | 512 | All indexed registers, register n at bits 8n+7:8n |

## Verification
The hardest case to reach from the ports is the place where the two guards and the key sequence overlap. Index 0x35 is exempt from the key guard but is blocked by the protect bit. The key only moves when a mode write arrives with a compatibility value from an earlier write, which may have come through the alias that the misc bit switches off. The stimulus first walks each path in a fixed order: locked and unlocked, protected and unprotected, alias on and off, and the key-hold cases. It then runs a long random phase biased toward 0x03, 0xA0, index 0x11 and the exempt indices, so that these combinations recur. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/xrg_pkg.sv
package xrg_pkg;
  localparam logic [15:0] PORT_COMPAT_ALT = 16'h03BF;
  localparam logic [15:0] PORT_COMPAT     = 16'h03DF;
  localparam logic [15:0] PORT_MODE       = 16'h03D8;
  localparam logic [15:0] PORT_MISC       = 16'h03C2;
  localparam logic [15:0] PORT_INDEX      = 16'h03D4;
  localparam logic [15:0] PORT_DATA       = 16'h03D5;

  typedef struct packed {
    logic compat_we;
    logic mode_we;
    logic misc_we;
    logic index_we;
    logic data_we;
  } xrg_strobe_t;
endpackage

// File: rtl/xrg_rst_sync.sv
module xrg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/xrg_port_decode.sv
module xrg_port_decode
  import xrg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              alt_en,
  output xrg_strobe_t       stb
);
  always_comb begin
    stb           = '0;
    stb.compat_we = io_we && ((io_addr == ADDR_W'(PORT_COMPAT)) ||
                              (alt_en && (io_addr == ADDR_W'(PORT_COMPAT_ALT))));
    stb.mode_we   = io_we && (io_addr == ADDR_W'(PORT_MODE));
    stb.misc_we   = io_we && (io_addr == ADDR_W'(PORT_MISC));
    stb.index_we  = io_we && (io_addr == ADDR_W'(PORT_INDEX));
    stb.data_we   = io_we && (io_addr == ADDR_W'(PORT_DATA));
  end
endmodule

// File: rtl/xrg_key_unit.sv
module xrg_key_unit #(
  parameter int               DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_CODE = 8'h03,
  parameter logic [DATA_W-1:0] KEY_MASK = 8'hA0,
  parameter logic [DATA_W-1:0] MISC_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              compat_we,
  input  logic              mode_we,
  input  logic              misc_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] compat,
  output logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] misc,
  output logic              key
);
  logic [DATA_W-1:0] compat_q, mode_q, misc_q;
  logic              key_q, key_d;
  logic              code_match, pattern_hit;

  always_comb begin
    code_match  = (compat_q == KEY_CODE);
    pattern_hit = ((wdata & KEY_MASK) == KEY_MASK);
    key_d       = key_q;
    if (mode_we) begin
      if (code_match && pattern_hit)        key_d = 1'b1;
      else if (!code_match && !pattern_hit) key_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      compat_q <= '0;
      mode_q   <= '0;
      misc_q   <= MISC_RST;
      key_q    <= 1'b0;
    end else begin
      if (compat_we) compat_q <= wdata;
      if (mode_we)   mode_q   <= wdata;
      if (misc_we)   misc_q   <= wdata;
      if (mode_we)   key_q    <= key_d;
    end
  end

  assign compat = compat_q;
  assign mode   = mode_q;
  assign misc   = misc_q;
  assign key    = key_q;
endmodule

// File: rtl/xrg_crtc_file.sv
module xrg_crtc_file #(
  parameter int                DATA_W    = 8,
  parameter int                IDX_W     = 6,
  parameter int                PROT_REG  = 'h11,
  parameter int                PROT_BIT  = 7,
  parameter int                LOW_LAST  = 6,
  parameter int                PART_IDX  = 7,
  parameter logic [DATA_W-1:0] PART_MASK = 8'h10,
  parameter int                OPEN_LAST = 'h18,
  parameter int                EXEMPT_A  = 'h33,
  parameter int                EXEMPT_B  = 'h35,
  localparam int               NREG      = 1 << IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     index_we,
  input  logic                     data_we,
  input  logic                     key,
  input  logic [DATA_W-1:0]        wdata,
  output logic [IDX_W-1:0]         index,
  output logic [DATA_W-1:0]        sel_data,
  output logic [NREG*DATA_W-1:0]   regs_flat
);
  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t I_PROT = idx_t'(PROT_REG);
  localparam idx_t I_LOW  = idx_t'(LOW_LAST);
  localparam idx_t I_PART = idx_t'(PART_IDX);
  localparam idx_t I_OPEN = idx_t'(OPEN_LAST);
  localparam idx_t I_EXA  = idx_t'(EXEMPT_A);
  localparam idx_t I_EXB  = idx_t'(EXEMPT_B);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  idx_t                        idx_q, idx_d;
  logic [NREG-1:0]             reg_en;
  logic                        prot, low_blk, ext_blk, data_ok, partial;
  logic [DATA_W-1:0]           wr_val;

  always_comb begin
    idx_d    = index_we ? wdata[IDX_W-1:0] : idx_q;
    sel_data = regs_q[idx_q];
    prot     = regs_q[I_PROT][PROT_BIT];
    low_blk  = prot && ((idx_q <= I_LOW) || (idx_q == I_EXB));
    ext_blk  = !key && (idx_q > I_OPEN) && (idx_q != I_EXA) && (idx_q != I_EXB);
    data_ok  = data_we && !low_blk && !ext_blk;
    partial  = prot && (idx_q == I_PART);
    wr_val   = partial ? ((sel_data & ~PART_MASK) | (wdata & PART_MASK)) : wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign reg_en[g] = data_ok && (idx_q == idx_t'(g));
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      regs_q <= '0;
    end else begin
      if (index_we) idx_q <= idx_d;
      for (int i = 0; i < NREG; i++) begin
        if (reg_en[i]) regs_q[i] <= wr_val;
      end
    end
  end

  assign index = idx_q;
endmodule

// File: rtl/crtc_guard.sv
module crtc_guard
  import xrg_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 8,
  parameter int  IDX_W  = 6,
  localparam int NREG   = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_we,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [DATA_W-1:0]      io_wdata,
  output logic [DATA_W-1:0]      io_rdata,
  output logic                   key_o,
  output logic [DATA_W-1:0]      compat_o,
  output logic [DATA_W-1:0]      mode_o,
  output logic [DATA_W-1:0]      misc_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [NREG*DATA_W-1:0] crtc_o
);
  logic              rst_n_s;
  xrg_strobe_t       stb;
  logic [DATA_W-1:0] sel_data;
  logic [DATA_W-1:0] misc_w;

  xrg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  xrg_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .io_we(io_we), .io_addr(io_addr), .alt_en(misc_w[0]), .stb(stb)
  );

  xrg_key_unit #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n_s),
    .compat_we(stb.compat_we), .mode_we(stb.mode_we), .misc_we(stb.misc_we),
    .wdata(io_wdata), .compat(compat_o), .mode(mode_o), .misc(misc_w), .key(key_o)
  );

  xrg_crtc_file #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_file (
    .clk(clk), .rst_n(rst_n_s),
    .index_we(stb.index_we), .data_we(stb.data_we), .key(key_o),
    .wdata(io_wdata), .index(idx_o), .sel_data(sel_data), .regs_flat(crtc_o)
  );

  always_comb begin
    if (io_addr == ADDR_W'(PORT_INDEX))     io_rdata = DATA_W'(idx_o);
    else if (io_addr == ADDR_W'(PORT_DATA)) io_rdata = sel_data;
    else                                    io_rdata = '0;
  end

  assign misc_o = misc_w;
endmodule

// File: rtl/crtc_guard_chk.sv
module crtc_guard_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         io_we,
  input logic [15:0]  io_addr,
  input logic [7:0]   io_wdata,
  input logic         key_o,
  input logic [7:0]   compat_o,
  input logic [7:0]   misc_o,
  input logic [5:0]   idx_o,
  input logic [511:0] crtc_o
);
  logic [7:0] sel_now;
  logic       prot_now, dat_wr, wr_hit;
  assign sel_now  = crtc_o[idx_o*8 +: 8];
  assign prot_now = crtc_o[8'h11*8 + 7];
  assign dat_wr   = io_we && (io_addr == 16'h03D5);
  assign wr_hit   = (io_wdata[7] && io_wdata[5]);

  p_key_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_o) |-> $past(io_we && io_addr == 16'h03D8 && compat_o == 8'h03 && wr_hit));

  p_key_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_o) |-> $past(io_we && io_addr == 16'h03D8 && compat_o != 8'h03 && !wr_hit));

  p_alt_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == 16'h03BF && !misc_o[0]) |=> $stable(compat_o));

  p_index_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == 16'h03D4) |=> (idx_o == $past(io_wdata[5:0])));

  p_low_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && prot_now && (idx_o < 6'd7 || idx_o == 6'h35)) |=> $stable(sel_now));

  p_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && prot_now && idx_o == 6'd7) |=>
      ((sel_now & 8'hEF) == ($past(sel_now) & 8'hEF)) && (sel_now[4] == $past(io_wdata[4])));

  p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !key_o && idx_o > 6'h18 && idx_o != 6'h33 && idx_o != 6'h35) |=> $stable(sel_now));
endmodule

bind crtc_guard crtc_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
  .key_o(key_o), .compat_o(compat_o), .misc_o(misc_o), .idx_o(idx_o), .crtc_o(crtc_o)
);

// File: tb/crtc_guard_tb_top.sv
`timescale 1ns/1ps
module crtc_guard_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         io_we;
  logic [15:0]  io_addr;
  logic [7:0]   io_wdata;
  logic [7:0]   io_rdata;
  logic         key_o;
  logic [7:0]   compat_o, mode_o, misc_o;
  logic [5:0]   idx_o;
  logic [511:0] crtc_o;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] m_crtc [64];
  logic [7:0] m_compat, m_mode, m_misc;
  logic [5:0] m_idx;
  logic       m_key;

  always #2.5 clk = ~clk;

  crtc_guard dut_i (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .key_o(key_o), .compat_o(compat_o), .mode_o(mode_o),
    .misc_o(misc_o), .idx_o(idx_o), .crtc_o(crtc_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dreg(input int i);
    return crtc_o[i*8 +: 8];
  endfunction

  function automatic logic [7:0] m_read(input logic [15:0] a);
    if (a == 16'h03D4) return {2'b00, m_idx};
    if (a == 16'h03D5) return m_crtc[m_idx];
    return 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 64; i++) m_crtc[i] = 8'h00;
    m_compat = 8'h00; m_mode = 8'h00; m_misc = 8'h01; m_idx = 6'd0; m_key = 1'b0;
  endtask

  task automatic m_apply(input logic [15:0] a, input logic [7:0] d);
    bit prot, both;
    int i;
    prot = m_crtc[17][7];
    i    = m_idx;
    both = d[7] && d[5];
    case (a)
      16'h03BF: if (m_misc[0]) m_compat = d;
      16'h03DF: m_compat = d;
      16'h03C2: m_misc = d;
      16'h03D8: begin
        m_mode = d;
        if (m_compat == 8'h03) begin
          if (both) m_key = 1'b1;
        end else if (!both) m_key = 1'b0;
      end
      16'h03D4: m_idx = d[5:0];
      16'h03D5: begin
        if (prot && (i < 7 || i == 53)) begin end
        else if (!m_key && i > 24 && i != 51 && i != 53) begin end
        else if (prot && i == 7) m_crtc[7][4] = d[4];
        else m_crtc[i] = d;
      end
      default: ;
    endcase
  endtask

  task automatic compare_all();
    bit bad = 0;
    chk("R3/R4 key", {7'b0, key_o}, {7'b0, m_key});
    chk("R2 compat", compat_o, m_compat);
    chk("R3 mode", mode_o, m_mode);
    chk("R2 misc", misc_o, m_misc);
    chk("R5 index", {2'b0, idx_o}, {2'b0, m_idx});
    for (int i = 0; i < 64; i++) begin
      if (!bad && dreg(i) !== m_crtc[i]) begin
        bad = 1;
        chk($sformatf("R6 reg %02h", i), dreg(i), m_crtc[i]);
      end
    end
    if (!bad) n_run++;
  endtask

  task automatic cyc(input logic we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    io_we = we; io_addr = a; io_wdata = d;
    #0.5;
    chk($sformatf("R10 rdata @%04h", a), io_rdata, m_read(a));
    @(posedge clk);
    if (we) m_apply(a, d);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle();
    cyc(1'b0, 16'h0000, 8'h00);
  endtask

  task automatic wreg(input logic [5:0] i, input logic [7:0] d);
    wr(16'h03D4, {2'b00, i});
    wr(16'h03D5, d);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    io_we = 0; io_addr = 0; io_wdata = 0;
    rst_n = 0;
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    idle();
    chk("R1 key reset", {7'b0, key_o}, 8'h00);
    chk("R1 misc reset", misc_o, 8'h01);
    chk("R1 reg 0x11 reset", dreg(17), 8'h00);

    wreg(6'h20, 8'h55);
    chk("R9 locked 0x20", dreg(32), 8'h00);
    wreg(6'h33, 8'h5A);
    chk("R9 exempt 0x33", dreg(51), 8'h5A);
    wreg(6'h18, 8'h3C);
    chk("R6 open 0x18", dreg(24), 8'h3C);

    wr(16'h03DF, 8'h03); wr(16'h03D8, 8'h80); idle();
    chk("R3 one bit no set", {7'b0, key_o}, 8'h00);
    wr(16'h03D8, 8'hA0); idle();
    chk("R3 key set", {7'b0, key_o}, 8'h01);
    wreg(6'h20, 8'h55);
    chk("R9 unlocked 0x20", dreg(32), 8'h55);
    wr(16'h03D8, 8'h00); idle();
    chk("R4 hold code match", {7'b0, key_o}, 8'h01);
    wr(16'h03DF, 8'h00); wr(16'h03D8, 8'hE0); idle();
    chk("R4 hold pattern", {7'b0, key_o}, 8'h01);
    wr(16'h03D8, 8'h20); idle();
    chk("R4 key clear", {7'b0, key_o}, 8'h00);

    wr(16'h03C2, 8'h00); wr(16'h03BF, 8'h77); idle();
    chk("R2 alias off", compat_o, 8'h00);
    wr(16'h03C2, 8'h01); wr(16'h03BF, 8'h03); idle();
    chk("R2 alias on", compat_o, 8'h03);

    wreg(6'h03, 8'h11);
    wreg(6'h07, 8'hE5);
    wreg(6'h35, 8'h44);
    wreg(6'h11, 8'h80);
    wreg(6'h03, 8'hFF);
    chk("R7 low frozen", dreg(3), 8'h11);
    wreg(6'h35, 8'hFF);
    chk("R7 0x35 frozen", dreg(53), 8'h44);
    wreg(6'h07, 8'h1A);
    chk("R8 partial", dreg(7), 8'hF5);
    wreg(6'h08, 8'h99);
    chk("R6 unprotected 0x08", dreg(8), 8'h99);
    cyc(1'b0, 16'h03D5, 8'h00);
    cyc(1'b0, 16'h03D4, 8'h00);
    chk("R5 read index", io_rdata, 8'h08);
    cyc(1'b0, 16'h03C2, 8'h00);
    chk("R10 other port", io_rdata, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int sel;
      sel = $urandom_range(0, 9);
      d   = 8'($urandom);
      case (sel)
        0: a = 16'h03BF;
        1: begin a = 16'h03DF; if ($urandom_range(0, 1) == 0) d = 8'h03; end
        2: begin a = 16'h03D8; if ($urandom_range(0, 1) == 0) d = 8'hA0; end
        3: begin a = 16'h03C2; d[0] = ($urandom_range(0, 3) != 0); end
        4: begin
          a = 16'h03D4;
          case ($urandom_range(0, 3))
            0: d = 8'h11;
            1: d = 8'h35;
            2: d = 8'h33;
            default: ;
          endcase
        end
        5, 6, 7: a = 16'h03D5;
        8: a = 16'h03C0;
        default: a = 16'h03D4;
      endcase
      cyc($urandom_range(0, 5) != 0, a, d);
    end
    idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule